// File: doc/BRIEF.md
# Endpoint transfer completion tracker

This block follows a single device endpoint's transfer from the moment its descriptor is armed until the transfer retires. A load strobe arms it with the total byte length. Each completed packet then reports how many bytes it actually carried, and the block deducts that amount from the running remaining count. Transfers in the two directions finish by different rules. A transmit transfer finishes only when the remaining count reaches zero. A receive transfer also finishes as soon as the host delivers a short packet: one whose byte count is below the configured maximum packet size, a zero-length packet included.

Error events set one of two sticky status bits, and the bit chosen depends on the endpoint type and the direction. The data-buffer error bit reports receive overflow. The transaction error bit reports isochronous packet errors and isochronous fulfillment errors. Isochronous packets are never retried, so any flagged error retires the transfer at once. Retirement is signalled by a one-clock done pulse. The remaining count and both error bits then hold their values until the next load.

The controller is a three-state machine:
- IDLE: waiting for a descriptor.
- ACTIVE: counting packets.
- RETIRE: lasts one cycle and drives the done pulse.

Its transitions are:
- LOAD: any state goes to ACTIVE on `arm`.
- FINISH: ACTIVE goes to RETIRE when a completion rule is met or an error is tagged.
- PULSE_END: RETIRE goes to IDLE.

Top module: `ep_xfer_tracker`

## Requirements
- R1: In the cycle after `arm` is high, `bytes_left` equals `arm_len`, both error bits are 0 and `xfer_done` is 0. `arm` takes priority over every other input in the same cycle.
- R2: While ACTIVE, a `pkt_cmpl` strobe whose `pkt_len` does not exceed `bytes_left` reduces `bytes_left` by `pkt_len` on the next cycle.
- R3: A transmit transfer (`is_rx`=0) retires only when the remaining count after a packet is zero. A short transmit packet with bytes still left does not retire it. A transmit `pkt_len` larger than `bytes_left` saturates the count at zero with no error.
- R4: A receive transfer (`is_rx`=1) retires when a packet leaves the count at zero or has `pkt_len` < MAX_PKT, with zero length counting as short. A full-size packet that leaves bytes remaining does not retire it.
- R5: `rx_ovf` while ACTIVE on a receive transfer sets `dbuf_err`, leaves `xact_err` clear and retires the transfer, whatever the `iso` setting.
- R6: A receive `pkt_len` greater than `bytes_left` is an overflow. It sets `dbuf_err` only, forces `bytes_left` to 0 and retires the transfer.
- R7: `iso_rx_err` while ACTIVE sets `xact_err` only and retires the transfer, but only when `iso`=1 and `is_rx`=1. Otherwise it has no effect.
- R8: `iso_ful_err` while ACTIVE with `iso`=1 sets `xact_err` only and retires the transfer in either direction. With `iso`=0 it has no effect.
- R9: `xfer_done` is high for exactly one cycle per retirement, the cycle after the finishing event. Outside ACTIVE, packet and error strobes change neither `bytes_left` nor the error bits.
- R10: After reset, `bytes_left` is 0, `xfer_done` is 0 and both error bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Descriptor load strobe |
| arm_len | input | CNT_W | Total transfer length in bytes |
| is_rx | input | 1 | 1 = receive (host to device), 0 = transmit |
| iso | input | 1 | 1 = isochronous endpoint |
| pkt_cmpl | input | 1 | Packet completed strobe |
| pkt_len | input | PKT_W | Bytes actually moved by the completed packet |
| rx_ovf | input | 1 | Receive data buffer overflow event |
| iso_rx_err | input | 1 | Isochronous receive packet error event |
| iso_ful_err | input | 1 | Isochronous fulfillment error event |
| bytes_left | output | CNT_W | Remaining byte count |
| xfer_done | output | 1 | One-cycle retirement pulse |
| dbuf_err | output | 1 | Sticky data-buffer error status |
| xact_err | output | 1 | Sticky transaction error status |

## Verification
Transmit runs are fed a sequence of full-size packets, then a short packet with bytes still left, then a final packet that empties the count. This separates the zero-only rule from the short-packet rule. Receive runs are given a full-size packet, a short packet, a zero-length packet and an oversized packet, to show where a receive ends early and where it turns into an overflow. Each error strobe is applied with every combination of direction and isochronous flag, to tell the tagged bit and the ignored cases apart. A long random run then interleaves loads, packets and errors, and checks every cycle against a reference model in the bench.

// File: rtl/ep_xfer_pkg.sv
package ep_xfer_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACTIVE = 2'd1,
        S_RETIRE = 2'd2
    } trk_state_t;
endpackage

// File: rtl/ep_xfer_count.sv
// Remaining-byte register with saturating subtraction and packet classification.
module ep_xfer_count #(
    parameter int CNT_W   = 16,
    parameter int PKT_W   = 11,
    parameter int MAX_PKT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             apply,
    input  logic [PKT_W-1:0] pkt_len,
    output logic [CNT_W-1:0] remain,
    output logic             nxt_zero,
    output logic             too_long,
    output logic             short_pkt
);
    localparam int PAD = CNT_W - PKT_W;

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] len_ext;
    logic [CNT_W-1:0] remain_nxt;

    always_comb begin
        len_ext    = {{PAD{1'b0}}, pkt_len};
        too_long   = len_ext > remain_q;
        remain_nxt = (len_ext >= remain_q) ? '0 : remain_q - len_ext;
        nxt_zero   = (remain_nxt == '0);
        short_pkt  = pkt_len < PKT_W'(MAX_PKT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_len;
        end else if (apply) begin
            remain_q <= remain_nxt;
        end
    end

    assign remain = remain_q;
endmodule

// File: rtl/ep_xfer_errtab.sv
// Fixed error table: maps events, direction and endpoint type onto two sticky bits.
module ep_xfer_errtab (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic is_rx,
    input  logic iso,
    input  logic rx_ovf,
    input  logic len_ovf,
    input  logic iso_rx_err,
    input  logic iso_ful_err,
    output logic dbuf_err,
    output logic xact_err,
    output logic hit
);
    logic set_dbuf;
    logic set_xact;
    logic dbuf_q;
    logic xact_q;

    always_comb begin
        set_dbuf = is_rx && (rx_ovf || len_ovf);
        set_xact = iso && (iso_ful_err || (is_rx && iso_rx_err));
        hit      = en && (set_dbuf || set_xact);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbuf_q <= 1'b0;
            xact_q <= 1'b0;
        end else if (clr) begin
            dbuf_q <= 1'b0;
            xact_q <= 1'b0;
        end else if (en) begin
            dbuf_q <= dbuf_q | set_dbuf;
            xact_q <= xact_q | set_xact;
        end
    end

    assign dbuf_err = dbuf_q;
    assign xact_err = xact_q;
endmodule

// File: rtl/ep_xfer_tracker.sv
module ep_xfer_tracker
    import ep_xfer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PKT_W   = 11,
    parameter int MAX_PKT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [CNT_W-1:0] arm_len,
    input  logic             is_rx,
    input  logic             iso,
    input  logic             pkt_cmpl,
    input  logic [PKT_W-1:0] pkt_len,
    input  logic             rx_ovf,
    input  logic             iso_rx_err,
    input  logic             iso_ful_err,
    output logic [CNT_W-1:0] bytes_left,
    output logic             xfer_done,
    output logic             dbuf_err,
    output logic             xact_err
);
    trk_state_t state_q;
    trk_state_t state_d;

    logic active;
    logic apply;
    logic nxt_zero;
    logic too_long;
    logic short_pkt;
    logic err_hit;
    logic finish;

    assign active = (state_q == S_ACTIVE) && !arm;
    assign apply  = active && pkt_cmpl;

    ep_xfer_count #(
        .CNT_W   (CNT_W),
        .PKT_W   (PKT_W),
        .MAX_PKT (MAX_PKT)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (arm),
        .load_len  (arm_len),
        .apply     (apply),
        .pkt_len   (pkt_len),
        .remain    (bytes_left),
        .nxt_zero  (nxt_zero),
        .too_long  (too_long),
        .short_pkt (short_pkt)
    );

    ep_xfer_errtab u_errtab (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (arm),
        .en          (active),
        .is_rx       (is_rx),
        .iso         (iso),
        .rx_ovf      (rx_ovf),
        .len_ovf     (pkt_cmpl && too_long),
        .iso_rx_err  (iso_rx_err),
        .iso_ful_err (iso_ful_err),
        .dbuf_err    (dbuf_err),
        .xact_err    (xact_err),
        .hit         (err_hit)
    );

    // Completion rule: transmit needs zero left; receive also ends on a short packet.
    always_comb begin
        finish = err_hit;
        if (pkt_cmpl) begin
            if (is_rx) begin
                finish = finish || nxt_zero || short_pkt;
            end else begin
                finish = finish || nxt_zero;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (arm) begin
            state_d = S_ACTIVE;
        end else begin
            unique case (state_q)
                S_IDLE:   state_d = S_IDLE;
                S_ACTIVE: state_d = finish ? S_RETIRE : S_ACTIVE;
                S_RETIRE: state_d = S_IDLE;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        xfer_done = 1'b0;
        unique case (state_q)
            S_IDLE:   xfer_done = 1'b0;
            S_ACTIVE: xfer_done = 1'b0;
            S_RETIRE: xfer_done = 1'b1;
            default:  xfer_done = 1'b0;
        endcase
    end
endmodule

// File: rtl/ep_xfer_tracker_chk.sv
module ep_xfer_tracker_chk
    import ep_xfer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PKT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic [CNT_W-1:0] arm_len,
    input logic             is_rx,
    input logic             pkt_cmpl,
    input logic [PKT_W-1:0] pkt_len,
    input logic [CNT_W-1:0] bytes_left,
    input logic             xfer_done,
    input logic             dbuf_err,
    input logic             xact_err,
    input trk_state_t       state
);
    logic [CNT_W-1:0] len_ext;
    assign len_ext = {{(CNT_W-PKT_W){1'b0}}, pkt_len};

    AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (bytes_left == $past(arm_len)) && !dbuf_err && !xact_err && !xfer_done); // R1

    AST_SUBTRACT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACTIVE && !arm && pkt_cmpl && len_ext <= bytes_left)
        |=> bytes_left == $past(bytes_left) - $past(len_ext)); // R2

    AST_TX_ZERO_END: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !dbuf_err && !xact_err && !$past(is_rx)) |-> bytes_left == '0); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R9

    AST_HOLD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_ACTIVE && !arm)
        |=> $stable(bytes_left) && $stable(dbuf_err) && $stable(xact_err)); // R9
endmodule

bind ep_xfer_tracker ep_xfer_tracker_chk #(
    .CNT_W (CNT_W),
    .PKT_W (PKT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .arm_len    (arm_len),
    .is_rx      (is_rx),
    .pkt_cmpl   (pkt_cmpl),
    .pkt_len    (pkt_len),
    .bytes_left (bytes_left),
    .xfer_done  (xfer_done),
    .dbuf_err   (dbuf_err),
    .xact_err   (xact_err),
    .state      (state_q)
);

// File: tb/tb_ep_xfer_tracker.sv
module tb_ep_xfer_tracker;
    localparam int CNT_W   = 16;
    localparam int PKT_W   = 11;
    localparam int MAX_PKT = 64;
    localparam time CLK_PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm = 1'b0;
    logic [CNT_W-1:0] arm_len = '0;
    logic             is_rx = 1'b0;
    logic             iso = 1'b0;
    logic             pkt_cmpl = 1'b0;
    logic [PKT_W-1:0] pkt_len = '0;
    logic             rx_ovf = 1'b0;
    logic             iso_rx_err = 1'b0;
    logic             iso_ful_err = 1'b0;
    logic [CNT_W-1:0] bytes_left;
    logic             xfer_done;
    logic             dbuf_err;
    logic             xact_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state: 0 idle, 1 active, 2 retire
    int m_st = 0;
    int m_rem = 0;
    bit m_dbuf = 0;
    bit m_xact = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep_xfer_tracker #(.CNT_W(CNT_W), .PKT_W(PKT_W), .MAX_PKT(MAX_PKT)) dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .arm_len(arm_len), .is_rx(is_rx),
        .iso(iso), .pkt_cmpl(pkt_cmpl), .pkt_len(pkt_len), .rx_ovf(rx_ovf),
        .iso_rx_err(iso_rx_err), .iso_ful_err(iso_ful_err), .bytes_left(bytes_left),
        .xfer_done(xfer_done), .dbuf_err(dbuf_err), .xact_err(xact_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat_sub(input int rem, input int n);
        return (n >= rem) ? 0 : rem - n;
    endfunction

    task automatic model_step(input bit ld, input int len, input bit pd, input int n,
                              input bit rx, input bit io, input bit ovf,
                              input bit ipe, input bit ife);
        if (ld) begin
            m_rem = len; m_dbuf = 0; m_xact = 0; m_st = 1;
        end else if (m_st == 1) begin
            bit sd;
            bit sx;
            bit fin;
            int nr;
            sd = rx && (ovf || (pd && n > m_rem));
            sx = io && (ife || (rx && ipe));
            nr = pd ? sat_sub(m_rem, n) : m_rem;
            fin = sd || sx || (pd && (nr == 0 || (rx && n < MAX_PKT)));
            m_rem = nr;
            m_dbuf = m_dbuf | sd;
            m_xact = m_xact | sx;
            m_st = fin ? 2 : 1;
        end else if (m_st == 2) begin
            m_st = 0;
        end
    endtask

    // Drive one cycle of inputs at a falling edge, clock, then sample at the next falling edge.
    task automatic cyc(input bit ld, input int len, input bit pd, input int n,
                       input bit rx, input bit io, input bit ovf,
                       input bit ipe, input bit ife);
        arm = ld; arm_len = CNT_W'(len); pkt_cmpl = pd; pkt_len = PKT_W'(n);
        is_rx = rx; iso = io; rx_ovf = ovf; iso_rx_err = ipe; iso_ful_err = ife;
        @(posedge clk);
        model_step(ld, len, pd, n, rx, io, ovf, ipe, ife);
        @(negedge clk);
        arm = 0; pkt_cmpl = 0; rx_ovf = 0; iso_rx_err = 0; iso_ful_err = 0;
    endtask

    task automatic expect_out(input string tag, input int rem, input bit d,
                              input bit db, input bit xe);
        chk({tag, " bytes_left"}, int'(bytes_left), rem);
        chk({tag, " xfer_done"}, int'(xfer_done), int'(d));
        chk({tag, " dbuf_err"}, int'(dbuf_err), int'(db));
        chk({tag, " xact_err"}, int'(xact_err), int'(xe));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        bit r_rx;
        bit r_iso;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R10 reset", 0, 0, 0, 0);

        // transmit: short packet with bytes left must not end it
        cyc(1, 150, 0, 0, 0, 0, 0, 0, 0);  expect_out("R1 tx load", 150, 0, 0, 0);
        cyc(0, 0, 1, 64, 0, 0, 0, 0, 0);   expect_out("R2 tx sub", 86, 0, 0, 0);
        cyc(0, 0, 1, 22, 0, 0, 0, 0, 0);   expect_out("R3 tx short no end", 64, 0, 0, 0);
        cyc(0, 0, 1, 64, 0, 0, 0, 0, 0);   expect_out("R3 tx zero end", 0, 1, 0, 0);
        cyc(0, 0, 1, 5, 0, 0, 0, 0, 0);    expect_out("R9 pulse ends, idle ignores pkt", 0, 0, 0, 0);
        // transmit oversize saturates without error
        cyc(1, 10, 0, 0, 0, 0, 0, 0, 0);   expect_out("R1 tx load 10", 10, 0, 0, 0);
        cyc(0, 0, 1, 30, 0, 0, 0, 0, 0);   expect_out("R3 tx saturate", 0, 1, 0, 0);

        // receive
        cyc(1, 200, 0, 0, 1, 0, 0, 0, 0);  expect_out("R1 rx load", 200, 0, 0, 0);
        cyc(0, 0, 1, 64, 1, 0, 0, 0, 0);   expect_out("R4 rx full no end", 136, 0, 0, 0);
        cyc(0, 0, 1, 10, 1, 0, 0, 0, 0);   expect_out("R4 rx short end", 126, 1, 0, 0);
        cyc(1, 100, 0, 0, 1, 0, 0, 0, 0);  expect_out("R1 reload clears", 100, 0, 0, 0);
        cyc(0, 0, 1, 0, 1, 0, 0, 0, 0);    expect_out("R4 rx zero-length end", 100, 1, 0, 0);
        cyc(1, 64, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, 64, 1, 0, 0, 0, 0);   expect_out("R4 rx exact zero end", 0, 1, 0, 0);

        // receive overflow by length
        cyc(1, 30, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, 40, 1, 0, 0, 0, 0);   expect_out("R6 rx too long", 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 1, 1, 1, 1, 1);    expect_out("R9 errors held outside active", 0, 0, 1, 0);
        // receive overflow event, isochronous too
        cyc(1, 500, 0, 0, 1, 1, 0, 0, 0);  expect_out("R1 load clears errors", 500, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 1, 1, 0, 0);    expect_out("R5 rx ovf", 500, 1, 1, 0);
        cyc(1, 500, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 1, 0, 0);    expect_out("R5 rx ovf non-iso", 500, 1, 1, 0);
        cyc(1, 500, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);    expect_out("R5 tx ovf ignored", 500, 0, 0, 0);

        // isochronous receive packet error
        cyc(1, 500, 0, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 1, 0, 1, 0);    expect_out("R7 iso rx err", 500, 1, 0, 1);
        cyc(1, 500, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 1, 0);    expect_out("R7 non-iso ignored", 500, 0, 0, 0);
        cyc(1, 500, 0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 1, 0);    expect_out("R7 iso tx ignored", 500, 0, 0, 0);

        // fulfillment error
        cyc(1, 300, 0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 1);    expect_out("R8 iso tx fulfil", 300, 1, 0, 1);
        cyc(1, 300, 0, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 1, 0, 0, 1);    expect_out("R8 iso rx fulfil", 300, 1, 0, 1);
        cyc(1, 300, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 1);    expect_out("R8 non-iso ignored", 300, 0, 0, 0);

        // load wins over a same-cycle packet and error
        cyc(1, 77, 1, 10, 1, 1, 1, 1, 1);  expect_out("R1 load priority", 77, 0, 0, 0);

        // constrained random against the model
        r_rx = 0; r_iso = 0;
        for (int i = 0; i < 4000; i++) begin
            bit ld;
            int len;
            int n;
            ld = ($urandom % 12) == 0;
            if (ld) begin
                r_rx = $urandom % 2;
                r_iso = $urandom % 2;
            end
            len = $urandom % 700;
            n = ($urandom % 3 == 0) ? MAX_PKT : int'($urandom % 90);
            cyc(ld, len, ($urandom % 2) == 1, n, r_rx, r_iso,
                ($urandom % 40) == 0, ($urandom % 40) == 0, ($urandom % 40) == 0);
            chk("R2 random bytes_left", int'(bytes_left), m_rem);
            chk("R9 random xfer_done", int'(xfer_done), int'(m_st == 2));
            chk("R5 random dbuf_err", int'(dbuf_err), int'(m_dbuf));
            chk("R8 random xact_err", int'(xact_err), int'(m_xact));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule